// File: doc/BRIEF.md
# Radix Tree Address Walker

This engine turns a 64-bit effective address into a real address. It walks a multi-level radix tree that lives in memory. A request carries the effective address, the process ID register and the process table register. The walker first fetches the process table entry selected by the effective PID. From that entry it takes the tree size, the root directory base and the root directory size. It then fetches one 8-byte directory entry per level until it reaches a leaf. At that point it reports the real address, or it reports a fault code instead.

At every step the table slot is formed by merging base-address bits with effective-address bits under a mask built from a size or shift value. No adder is used for this. Each size field is range-checked before the walk descends through it. Memory is reached over a plain read port with a request pulse, an address, an acknowledge and read data. Only one read is ever outstanding. Permission checks, reference and change checks, and translation caching are left to the surrounding logic.

Top module: `radix_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, `fault` is 0 and `real_addr` is 0.
- R2: The first read of a walk goes to this address: {8 zeros, table register bits 55:36, table register bits 35:12 with their lowest S bits replaced by PID bits 31:8, PID bits 7:0, 4 zeros}. S is table register bits 4:0 (S ≤ 24). The PID is the request PID, or zero when effective-address bit 63 is 1.
- R3: Process table doubleword fields (LSB-0 numbering): tree size = {bits 62:61, bits 7:5}; root base = bits 55:8 scaled by 256; root size = bits 4:0. The shift that applies before the root level is tree size + 19.
- R4: A segment fault (code 1) is raised if effective-address bit 63 differs from bit 62. It is also raised if any bit in 61:31 above the lowest tree-size positions is 1. This check takes priority over a size fault, and the walk then issues no directory read.
- R5: Every size field must lie in 5..16 and must not exceed the current shift. Otherwise the walk ends with a bad-tree fault (code 2). If the size passes, the new shift is the current shift minus the size.
- R6: A directory read address is the base with its address bits 3..size+2 replaced by the low size bits of (effective-address bits 55:12 shifted right by the new shift). Address bits 63:56 and 2:0 are zero.
- R7: In a directory entry, bit 63 is valid and bit 62 is leaf. A clear valid bit ends the walk with an invalid-entry fault (code 3), even when the leaf bit is set. A non-leaf entry supplies the next base (bits 55:8 scaled by 256) and the next size (bits 4:0).
- R8: On a leaf, the real address is {8 zeros, merged bits 55:12, effective-address bits 11:0}. In the merged bits, the lowest "current shift" positions come from the effective address and the rest come from the entry.
- R9: If a non-leaf entry arrives at the last allowed level (MAX_LEVELS directory reads), the walk ends with a bad-tree fault.
- R10: `mem_req` is a single-cycle pulse. No new read is issued until the previous one has been acknowledged.
- R11: `done` is a single-cycle pulse that carries the fault code (0 none, 1 segment, 2 bad tree, 3 invalid). Whenever the code is not 0, `real_addr` is 0.
- R12: `busy` is high from the cycle after a request is accepted until `done`. Requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_ea | input | 64 | Effective address |
| req_pid | input | 32 | Process ID register |
| req_prtbl | input | 64 | Process table register |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read doubleword |
| done | output | 1 | Walk finished pulse |
| fault | output | 2 | Fault code at done |
| real_addr | output | 64 | Translated real address at done |

## Verification
The bench first sweeps the process table size and the effective-address bit 63. This separates correct PID substitution and masking from swapped fields or an ignored PID override. A sweep of the root size field over every 5-bit value exposes any off-by-one at the 5 and 16 limits. A one-hot sweep over effective-address bits 31..61 with a zero tree size catches a shortened segment mask. The bench then runs full four-level walks, a huge-page leaf at level one, a cap overrun, a size greater than the shift, and an invalid leaf-flagged entry. Together these distinguish the shift bookkeeping, the index merge, the leaf merge and the order in which faults take priority.

// File: rtl/rw_pkg.sv
package rw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_SEGMENT = 2'd1,
    FLT_TREE    = 2'd2,
    FLT_INVALID = 2'd3
  } walk_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRT  = 2'd1,
    ST_DIR  = 2'd2
  } walk_state_e;

  localparam int unsigned SHIFT_W  = 6;
  localparam int unsigned SIZE_W   = 5;
  localparam int unsigned SEG_BIAS = 19;
endpackage

// File: rtl/rw_seg_size_check.sv
module rw_seg_size_check
  import rw_pkg::*;
#(
  parameter int unsigned MIN_SIZE = 5,
  parameter int unsigned MAX_SIZE = 16
) (
  input  logic [63:31]        ea_hi,
  input  logic [SIZE_W-1:0]   tree_size,
  input  logic [SHIFT_W-1:0]  cur_shift,
  input  logic [SIZE_W-1:0]   size_fld,
  output logic                seg_fault,
  output logic                size_bad,
  output logic [SHIFT_W-1:0]  next_shift
);
  logic [30:0] span_m;

  always_comb begin
    for (int i = 0; i < 31; i++) span_m[i] = (i < int'(tree_size));
    seg_fault  = (ea_hi[63] ^ ea_hi[62]) | (|(ea_hi[61:31] & ~span_m));
    size_bad   = (size_fld < SIZE_W'(MIN_SIZE)) | (size_fld > SIZE_W'(MAX_SIZE)) |
                 ({1'b0, size_fld} > cur_shift);
    next_shift = cur_shift - {1'b0, size_fld};
  end
endmodule

// File: rtl/rw_addr_gen.sv
module rw_addr_gen
  import rw_pkg::*;
(
  input  logic [55:12]        tbl_hi,
  input  logic [SIZE_W-1:0]   tbl_size,
  input  logic [31:0]         eff_pid,
  input  logic [55:8]         dir_base,
  input  logic [SIZE_W-1:0]   size_fld,
  input  logic [SHIFT_W-1:0]  idx_shift,
  input  logic [55:12]        ea_page,
  input  logic [11:0]         ea_off,
  input  logic [55:12]        leaf_page,
  input  logic [SHIFT_W-1:0]  leaf_shift,
  output logic [63:0]         prt_addr,
  output logic [63:0]         dir_addr,
  output logic [63:0]         leaf_addr
);
  logic [23:0] pid_m;
  logic [15:0] idx_m;
  logic [43:0] off_m;
  logic [43:0] ea_sh;
  logic [15:0] slot;
  logic        unused_sh;

  always_comb begin
    for (int i = 0; i < 24; i++) pid_m[i] = (i < int'(tbl_size));
    for (int i = 0; i < 16; i++) idx_m[i] = (i < int'(size_fld));
    for (int i = 0; i < 44; i++) off_m[i] = (i < int'(leaf_shift));
    ea_sh = ea_page >> idx_shift;
    slot  = ({dir_base[18:8], 5'b0} & ~idx_m) | (ea_sh[15:0] & idx_m);
    prt_addr  = {8'h00, tbl_hi[55:36],
                 (tbl_hi[35:12] & ~pid_m) | (eff_pid[31:8] & pid_m),
                 eff_pid[7:0], 4'h0};
    dir_addr  = {8'h00, dir_base[55:19], slot, 3'b000};
    leaf_addr = {8'h00, (leaf_page & ~off_m) | (ea_page & off_m), ea_off};
  end

  assign unused_sh = ^ea_sh[43:16];
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int unsigned MAX_LEVELS = 4,
  parameter int unsigned MIN_SIZE   = 5,
  parameter int unsigned MAX_SIZE   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_ea,
  input  logic [31:0] req_pid,
  input  logic [63:0] req_prtbl,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  output logic        done,
  output logic [1:0]  fault,
  output logic [63:0] real_addr
);
  localparam int unsigned LVL_W = $clog2(MAX_LEVELS + 1);

  logic [1:0]         rsync_q;
  logic               rst_int_n;
  walk_state_e        state_q, state_d;
  logic [63:0]        ea_q;
  logic               ea_en;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic               mreq_q, mreq_d;
  logic [63:0]        maddr_q, maddr_d;
  logic               done_q, done_d;
  walk_fault_e        fault_q, fault_d;
  logic [63:0]        ra_q, ra_d;

  logic [31:0]        eff_pid;
  logic [SIZE_W-1:0]  rts;
  logic [SHIFT_W-1:0] cur_shift, next_shift;
  logic               seg_fault, size_bad;
  logic [63:0]        prt_addr, dir_addr, leaf_addr;
  logic               unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign eff_pid   = req_ea[63] ? 32'd0 : req_pid;
  assign rts       = {mem_rdata[62:61], mem_rdata[7:5]};
  assign cur_shift = (state_q == ST_PRT) ? ({1'b0, rts} + SHIFT_W'(SEG_BIAS)) : shift_q;
  assign unused_bits = ^{mem_rdata[60:56], req_prtbl[63:56], req_prtbl[11:5]};

  rw_seg_size_check #(.MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE)) u_check (
    .ea_hi      (ea_q[63:31]),
    .tree_size  (rts),
    .cur_shift  (cur_shift),
    .size_fld   (mem_rdata[4:0]),
    .seg_fault  (seg_fault),
    .size_bad   (size_bad),
    .next_shift (next_shift)
  );

  rw_addr_gen u_addr (
    .tbl_hi     (req_prtbl[55:12]),
    .tbl_size   (req_prtbl[4:0]),
    .eff_pid    (eff_pid),
    .dir_base   (mem_rdata[55:8]),
    .size_fld   (mem_rdata[4:0]),
    .idx_shift  (next_shift),
    .ea_page    (ea_q[55:12]),
    .ea_off     (ea_q[11:0]),
    .leaf_page  (mem_rdata[55:12]),
    .leaf_shift (shift_q),
    .prt_addr   (prt_addr),
    .dir_addr   (dir_addr),
    .leaf_addr  (leaf_addr)
  );

  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    lvl_d   = lvl_q;
    mreq_d  = 1'b0;
    maddr_d = maddr_q;
    done_d  = 1'b0;
    fault_d = fault_q;
    ra_d    = ra_q;
    ea_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ea_en   = 1'b1;
          mreq_d  = 1'b1;
          maddr_d = prt_addr;
          lvl_d   = '0;
          state_d = ST_PRT;
        end
      end
      ST_PRT: begin
        if (mem_ack) begin
          if (seg_fault || size_bad) begin
            done_d  = 1'b1;
            fault_d = seg_fault ? FLT_SEGMENT : FLT_TREE;
            ra_d    = '0;
            state_d = ST_IDLE;
          end else begin
            mreq_d  = 1'b1;
            maddr_d = dir_addr;
            shift_d = next_shift;
            lvl_d   = LVL_W'(1);
            state_d = ST_DIR;
          end
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (!mem_rdata[63]) begin
            done_d  = 1'b1;
            fault_d = FLT_INVALID;
            ra_d    = '0;
            state_d = ST_IDLE;
          end else if (mem_rdata[62]) begin
            done_d  = 1'b1;
            fault_d = FLT_NONE;
            ra_d    = leaf_addr;
            state_d = ST_IDLE;
          end else if (lvl_q == LVL_W'(MAX_LEVELS) || size_bad) begin
            done_d  = 1'b1;
            fault_d = FLT_TREE;
            ra_d    = '0;
            state_d = ST_IDLE;
          end else begin
            mreq_d  = 1'b1;
            maddr_d = dir_addr;
            shift_d = next_shift;
            lvl_d   = lvl_q + LVL_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      shift_q <= '0;
      lvl_q   <= '0;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      ra_q    <= '0;
    end else begin
      state_q <= state_d;
      mreq_q  <= mreq_d;
      done_q  <= done_d;
      shift_q <= shift_d;
      lvl_q   <= lvl_d;
      maddr_q <= maddr_d;
      if (ea_en)  ea_q    <= req_ea;
      if (done_d) fault_q <= fault_d;
      if (done_d) ra_q    <= ra_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = mreq_q;
  assign mem_addr  = maddr_q;
  assign done      = done_q;
  assign fault     = fault_q;
  assign real_addr = ra_q;

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |=> !mem_req);
  p_req_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> busy);
  p_req_aligned_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> (mem_addr[63:56] == 8'h00 && mem_addr[2:0] == 3'b000));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  p_fault_no_addr_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && fault != FLT_NONE) |-> real_addr == 64'd0);
  p_idle_at_done_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);
  p_page_offset_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && fault == FLT_NONE) |-> real_addr[11:0] == ea_q[11:0]);
  p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    lvl_q <= LVL_W'(MAX_LEVELS));
endmodule

// File: tb/tb_radix_walker.sv
`timescale 1ns/1ps
module tb_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_ea;
  logic [31:0] req_pid;
  logic [63:0] req_prtbl;
  logic        busy, mem_req, mem_ack, done;
  logic [63:0] mem_addr, mem_rdata, real_addr;
  logic [1:0]  fault;

  int n_checks = 0;
  int n_errs   = 0;
  logic [63:0] ent [0:3];

  localparam logic [63:0] MID = 64'h00FF_FFFF_FFFF_F000;
  localparam logic [63:0] BSM = 64'h00FF_FFFF_FFFF_FF00;

  always #4 clk = ~clk;

  radix_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_pid(req_pid), .req_prtbl(req_prtbl), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .real_addr(real_addr)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_prt(logic [63:0] ea, logic [31:0] pid, logic [63:0] tbl);
    logic [63:0] epid, unit, keep, ins;
    int s;
    epid = ea[63] ? 64'd0 : {32'd0, pid};
    s    = int'(tbl[4:0]);
    unit = (tbl & MID) >> 12;
    keep = (unit >> s) << s;
    ins  = (epid >> 8) & ((64'd1 << s) - 1);
    return ((keep | ins) << 12) | ((epid & 64'hFF) << 4);
  endfunction

  function automatic logic [63:0] exp_dir(logic [63:0] base, int mb, int sh, logic [63:0] ea);
    logic [63:0] page, idx;
    page = (ea & MID) >> 12;
    idx  = (page >> sh) & ((64'd1 << mb) - 1);
    return ((base >> (mb + 3)) << (mb + 3)) | (idx << 3);
  endfunction

  function automatic logic [63:0] exp_ra(logic [63:0] leaf, int sh, logic [63:0] ea);
    logic [63:0] lp, page;
    lp   = (leaf & MID) >> 12;
    page = (ea & MID) >> 12;
    return ((((lp >> sh) << sh) | (page & ((64'd1 << sh) - 1))) << 12) | (ea & 64'hFFF);
  endfunction

  // answer one read: check address and pulse shape, optionally poke a request, then ack
  task automatic serve(input string req, input logic [63:0] exp_a, input logic [63:0] data,
                       input bit poke);
    int t = 0;
    while (!mem_req && t < 50) begin @(negedge clk); t++; end
    chk(req, mem_addr, exp_a);
    @(negedge clk);
    chk("R10 request pulse", {63'd0, mem_req}, 64'd0);
    if (poke) begin
      chk("R12 busy during walk", {63'd0, busy}, 64'd1);
      req_valid = 1'b1; req_ea = 64'h8000_0000_0000_0000; req_pid = 32'hFFFF_FFFF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    mem_ack = 1'b1; mem_rdata = data;
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = '0;
  endtask

  task automatic run_walk(input string tag, input logic [63:0] ea, input logic [31:0] pid,
                          input logic [63:0] tbl, input logic [63:0] prte, input int nreads,
                          input logic [1:0] exp_f, input bit poke);
    int sh, mb, t;
    logic [63:0] base;
    logic [63:0] pea;
    pea = ea;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_pid = pid; req_prtbl = tbl;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", {63'd0, busy}, 64'd1);
    serve("R2 process table address", exp_prt(ea, pid, tbl), prte, poke);
    sh   = int'({prte[62:61], prte[7:5]}) + 19;
    mb   = int'(prte[4:0]);
    base = prte & BSM;
    for (int k = 0; k < nreads; k++) begin
      sh = sh - mb;
      serve("R6 directory address", exp_dir(base, mb, sh, pea), ent[k], 1'b0);
      mb   = int'(ent[k][4:0]);
      base = ent[k] & BSM;
    end
    t = 0;
    while (!done && t < 20) begin
      if (mem_req) chk("R10 unexpected read", mem_addr, 64'hDEAD);
      @(negedge clk); t++;
    end
    chk({tag, " done"}, {63'd0, done}, 64'd1);
    chk({tag, " fault code"}, {62'd0, fault}, {62'd0, exp_f});
    chk("R12 idle at done", {63'd0, busy}, 64'd0);
    if (exp_f == 2'd0) chk("R8 real address", real_addr, exp_ra(ent[nreads-1], sh, pea));
    else               chk("R11 no address on fault", real_addr, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_pid = '0; req_prtbl = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R1 reset done", {63'd0, done}, 64'd0);
    chk("R1 reset mem_req", {63'd0, mem_req}, 64'd0);
    chk("R1 reset fault", {62'd0, fault}, 64'd0);
    chk("R1 reset real_addr", real_addr, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {63'd0, busy}, 64'd0);

    // R2: PID merge over table sizes, PID override by ea[63]; root size 4 -> bad tree (R5)
    foreach (ent[i]) ent[i] = '0;
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 2; h++) begin
        int sz = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 8 : 24;
        run_walk("R2 R5", h ? 64'hC000_0000_0000_1000 : 64'h0000_0000_1234_5000,
                 32'hABCD_E5F7, 64'hFF12_3456_789A_B000 | 64'(sz), 64'h0000_0000_0000_0004,
                 0, 2'd2, 1'b0);
      end
    end

    // R3 R5: root size sweep with tree size 31; valid sizes reach an invalid entry (R7)
    for (int z = 0; z < 32; z++) begin
      logic [63:0] p;
      p = 64'h6000_0000_0000_0000 | 64'h00AB_CDEF_1234_5600 | 64'hE0 | 64'(z);
      if (z >= 5 && z <= 16)
        run_walk("R3 R7", 64'h00F5_A5A5_1234_5000, 32'h0, 64'h0000_0000_0001_0000, p, 1, 2'd3, 1'b0);
      else
        run_walk("R5 size range", 64'h00F5_A5A5_1234_5000, 32'h0, 64'h0000_0000_0001_0000, p, 0, 2'd2, 1'b0);
    end

    // R4: segment faults
    run_walk("R4 top bits differ", 64'h8000_0000_0000_0000, 32'h5, 64'h1_0000, 64'h0000_0000_0040_000A, 0, 2'd1, 1'b0);
    run_walk("R4 priority over size", 64'h4000_0000_0000_0000, 32'h5, 64'h1_0000, 64'h0000_0000_0040_0004, 0, 2'd1, 1'b0);
    for (int b = 31; b < 62; b++)
      run_walk("R4 stray bit", 64'd1 << b, 32'h0, 64'h1_0000, 64'h0000_0000_0040_000A, 0, 2'd1, 1'b0);
    ent[0] = 64'h0;
    run_walk("R4 bit inside tree", 64'h0000_0000_8000_0000, 32'h0, 64'h1_0000, 64'h0000_0000_0040_0025, 1, 2'd3, 1'b0);
    run_walk("R4 bit above tree", 64'h0000_0001_8000_0000, 32'h0, 64'h1_0000, 64'h0000_0000_0040_0025, 0, 2'd1, 1'b0);

    // full four-level walk to a 4K page, with a request poked while busy (R12)
    ent[0] = 64'h8000_0000_0ABC_0009;
    ent[1] = 64'h8000_0003_3330_0009;
    ent[2] = 64'h8000_0000_7770_0009;
    ent[3] = 64'hC000_00FE_DCBA_9000;
    run_walk("R6 R8 R12 four levels", 64'h0000_0ABC_DEF1_2345, 32'h77, 64'h0000_0000_0020_0004,
             64'h4000_0012_3450_00AD, 4, 2'd0, 1'b1);

    // huge page leaf at the root level (R8)
    ent[0] = 64'hC000_0055_5555_5000;
    run_walk("R8 huge page", 64'h0000_0ABC_DEF1_2345, 32'h77, 64'h0000_0000_0020_0004,
             64'h4000_0012_3450_00AD, 1, 2'd0, 1'b0);
    run_walk("R2 R8 pid override", 64'hC000_0000_7654_3ABC, 32'h1234_5678, 64'h0000_0000_0030_0008,
             64'h4000_0012_3450_00AD, 1, 2'd0, 1'b0);

    // R9: level cap with shift still available
    ent[0] = 64'h8000_0000_0020_0005;
    ent[1] = 64'h8000_0000_0030_0005;
    ent[2] = 64'h8000_0000_0040_0005;
    ent[3] = 64'h8000_0000_0050_0005;
    run_walk("R9 level cap", 64'h0012_3456_789A_B000, 32'h0, 64'h1_0000, 64'h6000_0000_0010_00E5, 4, 2'd2, 1'b0);

    // R5: next size larger than remaining shift
    ent[0] = 64'h8000_0000_0050_0005;
    run_walk("R5 size over shift", 64'h0000_0000_1234_5000, 32'h0, 64'h1_0000, 64'h0000_0000_0040_0010, 1, 2'd2, 1'b0);

    // R7: leaf flag without valid at level two
    ent[0] = 64'h8000_0000_0ABC_0009;
    ent[1] = 64'h4000_0000_1111_1000;
    run_walk("R7 invalid entry", 64'h0000_0ABC_DEF1_2345, 32'h77, 64'h0000_0000_0020_0004,
             64'h4000_0012_3450_00AD, 2, 2'd3, 1'b0);

    summary();
  end
endmodule